// File: doc/BRIEF.md
# Oversampled Serial Command Receiver

This block lets a host computer drive a stopwatch over a serial line. It receives asynchronous 8N1 characters at 9600 baud on a single wire, clocked from a 10 MHz system clock. The raw line first passes through a two-stage flip-flop synchronizer. A 16x oversampling state machine then frames each character and assembles its byte. Three ASCII capital letters are turned into single-cycle control strobes: 'S' (0x53) for start/pause, 'L' (0x4C) for lap and 'R' (0x52) for soft reset. Every other byte is dropped without effect.

The oversampling tick comes from a divide-by-65 counter. The counter is held cleared while the receiver is idle, so sample timing is measured from the detected start edge. The frame state machine has four named states:

- `RX_IDLE` waits for a falling edge on the synchronized line (transition IDLE→START).
- `RX_START` counts eight ticks and re-checks the line. A high line is a false start (START→IDLE); a low line is a real start (START→DATA).
- `RX_DATA` takes eight bits, one every sixteen ticks at mid-bit, least significant bit first. After the last bit it moves to the stop bit (DATA→STOP).
- `RX_STOP` samples the stop bit at mid-bit and always returns to idle (STOP→IDLE). A high stop bit releases the byte. A low stop bit raises the framing-error flag.

Top module: `uart_cmd_rx`

## Requirements
- R1: The RX line reaches the frame logic only through a two-flip-flop synchronizer. The receiver leaves `RX_IDLE` only after a high-to-low change of `rx_i`, and no earlier than three clock edges after `rx_i` went low.
- R2: While a frame is in progress, the oversampling tick fires once every 65 clocks. The first tick comes 65 clocks after the start edge is seen.
- R3: At the eighth tick of the start bit the line is re-checked. If it is high, the receiver returns to idle with no strobe and no change to the framing-error flag, and it then accepts the next frame normally.
- R4: Each data bit is sampled at its sixteen-tick midpoint, and the byte is assembled least significant bit first.
- R5: A received byte 0x53 ('S') with a valid stop bit produces exactly one pulse on `start_pause_o`.
- R6: A received byte 0x4C ('L') with a valid stop bit produces exactly one pulse on `lap_o`.
- R7: A received byte 0x52 ('R') with a valid stop bit produces exactly one pulse on `soft_reset_o`.
- R8: Any other byte, including lowercase 0x73 ('s'), produces no strobe.
- R9: A stop bit sampled low sets `frame_err_o` and produces no strobe for that byte. The flag stays set until a later frame ends with a high stop bit, which clears it.
- R10: Every strobe lasts exactly one clock cycle, and at most one strobe is high in any cycle.
- R11: While reset is held and right after it is released, all three strobes and `frame_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (10 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Raw serial receive line, idle high |
| start_pause_o | output | 1 | One-cycle strobe on 'S' |
| lap_o | output | 1 | One-cycle strobe on 'L' |
| soft_reset_o | output | 1 | One-cycle strobe on 'R' |
| frame_err_o | output | 1 | Set by a low stop bit, cleared by the next good frame |

## Verification
The bench sends seeded random bytes, with the three command letters mixed in, and compares the strobe counts per frame with a decode function. A design that sampled off-centre or shifted the byte the wrong way round would decode the wrong letter, or none. Directed cases cover a short low glitch, which a design without the start re-check would take as a frame. They also cover a low stop bit followed by a held-low line: a design that strobed anyway would give a spurious command, and one that retriggered on the low level would lock into garbage frames. A later good frame must clear the error flag, and the lowercase letter must stay silent.

// File: rtl/uart_cmd_pkg.sv
package uart_cmd_pkg;

    // Frame state machine states
    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_e;

    // Defaults for 9600 baud at 16x from 10 MHz
    localparam int unsigned DEF_CLK_DIV   = 65;
    localparam int unsigned DEF_OSR       = 16;
    localparam int unsigned DEF_DATA_BITS = 8;
    localparam int unsigned DEF_SYNC      = 2;

    // Command indices into the code table
    localparam int unsigned CMD_START = 0;
    localparam int unsigned CMD_LAP   = 1;
    localparam int unsigned CMD_RESET = 2;
    localparam int unsigned NUM_CMDS  = 3;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[0] <= RESET_VAL;
                    else         chain_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge rst_ni) begin
                    if (!rst_ni) chain_q[g] <= RESET_VAL;
                    else         chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/os_tick_div.sv
module os_tick_div #(
    parameter int unsigned DIV = 65
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);

    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick_o = !clr_i && (cnt_q == CNT_LAST);

endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import uart_cmd_pkg::*;
#(
    parameter int unsigned OSR       = 16,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 rx_s_i,
    input  logic                 tick_i,
    output logic                 tick_clr_o,
    output logic [DATA_BITS-1:0] byte_o,
    output logic                 byte_vld_o,
    output logic                 frame_err_o,
    output rx_state_e            state_o
);

    localparam int unsigned SW = $clog2(OSR);
    localparam int unsigned BW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [SW-1:0] SAMP_MID  = SW'(OSR / 2 - 1);
    localparam logic [SW-1:0] SAMP_LAST = SW'(OSR - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(DATA_BITS - 1);

    rx_state_e            state_q, state_d;
    logic [SW-1:0]        samp_q;
    logic [BW-1:0]        bit_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic                 prev_q;
    logic                 fall;
    logic                 at_mid;
    logic                 at_last;

    assign fall    = prev_q && !rx_s_i;
    assign at_mid  = tick_i && (samp_q == SAMP_MID);
    assign at_last = tick_i && (samp_q == SAMP_LAST);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE: begin
                if (fall) state_d = RX_START;
            end
            RX_START: begin
                if (at_mid) state_d = rx_s_i ? RX_IDLE : RX_DATA;
            end
            RX_DATA: begin
                if (at_last && (bit_q == BIT_LAST)) state_d = RX_STOP;
            end
            RX_STOP: begin
                if (at_last) state_d = RX_IDLE;
            end
            default: state_d = RX_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RX_IDLE;
        else         state_q <= state_d;
    end

    // Sample, bit and shift datapath
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            samp_q  <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
            prev_q  <= 1'b1;
        end else begin
            prev_q <= rx_s_i;
            if ((state_q == RX_IDLE) || (state_d != state_q)) begin
                samp_q <= '0;
            end else if (tick_i) begin
                samp_q <= samp_q + 1'b1;
            end
            if (state_q != RX_DATA) begin
                bit_q <= '0;
            end else if (at_last) begin
                bit_q   <= bit_q + 1'b1;
                shreg_q <= {rx_s_i, shreg_q[DATA_BITS-1:1]};
            end
        end
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            byte_vld_o  <= 1'b0;
            frame_err_o <= 1'b0;
        end else begin
            byte_vld_o <= (state_q == RX_STOP) && at_last && rx_s_i;
            if ((state_q == RX_STOP) && at_last) begin
                frame_err_o <= !rx_s_i;
            end
        end
    end

    assign tick_clr_o = (state_q == RX_IDLE);
    assign byte_o     = shreg_q;
    assign state_o    = state_q;

endmodule

// File: rtl/cmd_strobe_dec.sv
module cmd_strobe_dec #(
    parameter int unsigned                       DATA_BITS = 8,
    parameter int unsigned                       NUM       = 3,
    parameter logic [NUM-1:0][DATA_BITS-1:0]     CODES     = '0
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [DATA_BITS-1:0] byte_i,
    input  logic                 vld_i,
    output logic [NUM-1:0]       strobe_o
);

    generate
        for (genvar g = 0; g < NUM; g++) begin : g_cmd
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) strobe_o[g] <= 1'b0;
                else         strobe_o[g] <= vld_i && (byte_i == CODES[g]);
            end
        end
    endgenerate

endmodule

// File: rtl/uart_cmd_rx.sv
module uart_cmd_rx
    import uart_cmd_pkg::*;
#(
    parameter int unsigned CLK_DIV   = DEF_CLK_DIV,
    parameter int unsigned OSR       = DEF_OSR,
    parameter int unsigned DATA_BITS = DEF_DATA_BITS,
    parameter int unsigned SYNC      = DEF_SYNC,
    parameter logic [7:0]  CODE_GO   = 8'h53,
    parameter logic [7:0]  CODE_LAP  = 8'h4C,
    parameter logic [7:0]  CODE_RST  = 8'h52
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rx_i,
    output logic start_pause_o,
    output logic lap_o,
    output logic soft_reset_o,
    output logic frame_err_o
);

    localparam logic [NUM_CMDS-1:0][DATA_BITS-1:0] CODE_TAB =
        {DATA_BITS'(CODE_RST), DATA_BITS'(CODE_LAP), DATA_BITS'(CODE_GO)};

    logic                 rx_sync;
    logic                 tick;
    logic                 tick_clr;
    logic [DATA_BITS-1:0] rx_byte;
    logic                 rx_vld;
    logic [NUM_CMDS-1:0]  strobes;
    rx_state_e            fsm_state;

    rx_line_sync #(
        .STAGES   (SYNC),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (rx_i),
        .q_o   (rx_sync)
    );

    os_tick_div #(
        .DIV(CLK_DIV)
    ) u_div (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .clr_i (tick_clr),
        .tick_o(tick)
    );

    rx_frame_fsm #(
        .OSR      (OSR),
        .DATA_BITS(DATA_BITS)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .rx_s_i     (rx_sync),
        .tick_i     (tick),
        .tick_clr_o (tick_clr),
        .byte_o     (rx_byte),
        .byte_vld_o (rx_vld),
        .frame_err_o(frame_err_o),
        .state_o    (fsm_state)
    );

    cmd_strobe_dec #(
        .DATA_BITS(DATA_BITS),
        .NUM      (NUM_CMDS),
        .CODES    (CODE_TAB)
    ) u_dec (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .byte_i  (rx_byte),
        .vld_i   (rx_vld),
        .strobe_o(strobes)
    );

    assign start_pause_o = strobes[CMD_START];
    assign lap_o         = strobes[CMD_LAP];
    assign soft_reset_o  = strobes[CMD_RESET];

endmodule

// File: rtl/uart_cmd_rx_chk.sv
module uart_cmd_rx_chk
    import uart_cmd_pkg::*;
#(
    parameter int unsigned CLK_DIV = DEF_CLK_DIV
) (
    input logic      clk_i,
    input logic      rst_ni,
    input logic      rx_i,
    input logic      tick,
    input rx_state_e fsm_state,
    input logic      start_pause_o,
    input logic      lap_o,
    input logic      soft_reset_o,
    input logic      frame_err_o
);

    localparam int unsigned GW = $clog2(CLK_DIV) + 1;

    logic [GW-1:0] gap_q;
    logic          any_strobe;

    assign any_strobe = start_pause_o | lap_o | soft_reset_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     gap_q <= '0;
        else if (fsm_state == RX_IDLE)   gap_q <= '0;
        else if (tick)                   gap_q <= '0;
        else                             gap_q <= gap_q + 1'b1;
    end

    AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fsm_state == RX_START && $past(fsm_state) == RX_IDLE) |-> ($past(rx_i, 3) == 1'b0)) // R1
        else $error("start left idle without a synchronized low line");

    AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick |-> (gap_q == GW'(CLK_DIV - 1))) // R2
        else $error("oversampling tick spacing wrong");

    AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({start_pause_o, lap_o, soft_reset_o})) // R10
        else $error("more than one strobe high");

    AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        any_strobe |=> !any_strobe) // R10
        else $error("strobe longer than one cycle");

    AST_FERR_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(frame_err_o) |-> (!any_strobe ##1 !any_strobe)) // R9
        else $error("strobe issued for a badly framed byte");

endmodule

bind uart_cmd_rx uart_cmd_rx_chk #(
    .CLK_DIV(CLK_DIV)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_i         (rx_i),
    .tick         (tick),
    .fsm_state    (fsm_state),
    .start_pause_o(start_pause_o),
    .lap_o        (lap_o),
    .soft_reset_o (soft_reset_o),
    .frame_err_o  (frame_err_o)
);

// File: tb/sim_uart_cmd_rx.sv
`timescale 1ns/1ps
module sim_uart_cmd_rx;

    localparam int BIT_CLKS = 65 * 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx = 1'b1;
    logic st_o, lap_o, rst_o, ferr_o;

    int checks = 0;
    int failures = 0;
    int n_st = 0, n_lap = 0, n_rst = 0;
    bit done = 1'b0;
    logic prev_any = 1'b0;

    always #2 clk = ~clk;

    uart_cmd_rx u0 (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .rx_i         (rx),
        .start_pause_o(st_o),
        .lap_o        (lap_o),
        .soft_reset_o (rst_o),
        .frame_err_o  (ferr_o)
    );

    // Strobe monitor: counts pulses, checks width and exclusivity (R10)
    always @(negedge clk) begin
        if (rst_n) begin
            if (st_o)  n_st++;
            if (lap_o) n_lap++;
            if (rst_o) n_rst++;
            if ((32'(st_o) + 32'(lap_o) + 32'(rst_o)) > 1) begin
                failures++;
                $display("FAIL R10 strobes together: act=%b%b%b exp=at most one", st_o, lap_o, rst_o);
            end
            if (prev_any && (st_o | lap_o | rst_o)) begin
                failures++;
                $display("FAIL R10 strobe wider than one cycle: act=2 cycles exp=1");
            end
            prev_any <= st_o | lap_o | rst_o;
        end
    end

    // Expected command index: 0 none, 1 start, 2 lap, 3 reset
    function automatic int exp_cmd(input logic [7:0] b);
        case (b)
            8'h53:   return 1;
            8'h4C:   return 2;
            8'h52:   return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input bit stop_ok);
        rx = 1'b0;
        repeat (BIT_CLKS) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (BIT_CLKS) @(negedge clk);
        end
        rx = stop_ok;
        repeat (BIT_CLKS) @(negedge clk);
        if (!stop_ok) begin
            repeat (BIT_CLKS) @(negedge clk);
            rx = 1'b1;
        end
        repeat (200) @(negedge clk);
    endtask

    task automatic frame_and_check(input string tag, input logic [7:0] b);
        int s0, l0, r0, e;
        s0 = n_st; l0 = n_lap; r0 = n_rst;
        e = exp_cmd(b);
        send_frame(b, 1'b1);
        check({tag, " start strobes"}, n_st - s0, (e == 1) ? 1 : 0);
        check({tag, " lap strobes"},   n_lap - l0, (e == 2) ? 1 : 0);
        check({tag, " reset strobes"}, n_rst - r0, (e == 3) ? 1 : 0);
        check({tag, " ferr after good frame (R9)"}, int'(ferr_o), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int s0, l0, r0;
        logic [7:0] b;
        void'($urandom(32'h1234_5EED));

        // R11: reset state
        repeat (5) @(negedge clk);
        check("R11 strobes in reset", int'(st_o | lap_o | rst_o), 0);
        check("R11 ferr in reset", int'(ferr_o), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 strobes after reset", int'(st_o | lap_o | rst_o), 0);
        check("R11 ferr after reset", int'(ferr_o), 0);

        // Directed command letters
        frame_and_check("R5 R4 'S'", 8'h53);
        frame_and_check("R6 R4 'L'", 8'h4C);
        frame_and_check("R7 R4 'R'", 8'h52);
        frame_and_check("R8 lowercase 's'", 8'h73);

        // R9: low stop bit on an 'S'
        s0 = n_st; l0 = n_lap; r0 = n_rst;
        send_frame(8'h53, 1'b0);
        check("R9 ferr set by low stop", int'(ferr_o), 1);
        check("R9 no strobe on bad frame", (n_st - s0) + (n_lap - l0) + (n_rst - r0), 0);
        frame_and_check("R9 R6 recovery 'L'", 8'h4C);

        // R3: short glitch is a false start
        s0 = n_st; l0 = n_lap; r0 = n_rst;
        rx = 1'b0;
        repeat (300) @(negedge clk);
        rx = 1'b1;
        repeat (BIT_CLKS * 2) @(negedge clk);
        check("R3 no strobe on glitch", (n_st - s0) + (n_lap - l0) + (n_rst - r0), 0);
        check("R3 ferr unchanged by glitch", int'(ferr_o), 0);
        frame_and_check("R3 R7 'R' after glitch", 8'h52);

        // Random bytes, biased toward command letters (R4, R5-R8)
        for (int k = 0; k < 5; k++) begin
            case ($urandom % 5)
                0:       b = 8'h53;
                1:       b = 8'h4C;
                2:       b = 8'h52;
                default: b = 8'($urandom);
            endcase
            frame_and_check($sformatf("R4 R8 random 0x%02h", b), b);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule